// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept. The receive path gives it the six destination bytes and a 6-bit multicast hash index near the start of the frame. At the end of the frame it gives the frame length and the CRC and alignment error flags. The filter compares the destination with the station address, the broadcast address and a 64-bit multicast hash table. It then qualifies the result against the length and error rules set by the configuration bits.

The verdict is a one-cycle accept or reject pulse, registered one cycle after end-of-frame. A group bit beside it tells whether the frame came in on a physical address or on a group (multicast or broadcast) address. The same stage also gives a remote transmitter control. When that feature is enabled, a clean group frame whose hash index is 62 produces a transmitter-off pulse, and one whose hash index is 63 produces a transmitter-on pulse.

Top module: `rx_dest_filter`

## Requirements
- R1: With promiscuous mode off, a physical destination (bit 0 of the first byte `dst_i[7:0]` clear) is accepted when all six bytes equal `stn_addr_i`, and rejected otherwise. Byte k of either address sits in bits [8k+7:8k].
- R2: A destination of all 48 ones is accepted only when `cfg_bcast_i` is 1.
- R3: A non-broadcast group destination is rejected when `cfg_mcast_i` is 0. When `cfg_mcast_i` is 1 it is accepted exactly when the hash table bit is set. For hash index idx, that bit is bit idx[2:0] of table byte idx[5:3], where table byte k is `hash_tbl_i[8k+7:8k]`.
- R4: With `cfg_promisc_i` set, every physical destination is accepted, whether or not it matches the station address.
- R5: A frame whose length is below 64 bytes is rejected unless `cfg_runt_i` is set. A frame of exactly 64 bytes is not a runt.
- R6: A frame with `crc_err_i` or `align_err_i` set is rejected unless `cfg_save_err_i` is set.
- R7: On every accept, `group_o` is 0 for acceptance through a physical address and 1 for a group address. It holds that value until the next verdict.
- R8: For each `eof_i` cycle, exactly one of `accept_o` and `reject_o` is high for exactly one cycle, in the cycle after `eof_i`. Neither is high at any other time.
- R9: When `cfg_atd_i` is set and the frame has a group destination and no CRC or alignment error, hash index 62 pulses `tx_off_o` and hash index 63 pulses `tx_on_o`, in the same cycle as the verdict. With `cfg_atd_i` clear, neither pulses. These pulses do not depend on the accept decision.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_valid_i | input | 1 | Destination address and hash index are valid |
| dst_i | input | 48 | Destination address, first byte in [7:0] |
| hash_idx_i | input | 6 | Precomputed multicast hash index |
| eof_i | input | 1 | End of frame; length and error flags are valid |
| frame_len_i | input | 11 | Frame length in bytes |
| crc_err_i | input | 1 | Frame failed its CRC |
| align_err_i | input | 1 | Frame did not end on a byte boundary |
| stn_addr_i | input | 48 | Station address, first byte in [7:0] |
| hash_tbl_i | input | 64 | Multicast hash table, byte k in [8k+7:8k] |
| cfg_bcast_i | input | 1 | Accept broadcast |
| cfg_mcast_i | input | 1 | Accept hashed multicast |
| cfg_promisc_i | input | 1 | Accept any physical destination |
| cfg_runt_i | input | 1 | Keep frames shorter than 64 bytes |
| cfg_save_err_i | input | 1 | Keep frames with CRC or alignment errors |
| cfg_atd_i | input | 1 | Enable remote transmitter off/on |
| accept_o | output | 1 | One-cycle accept pulse |
| reject_o | output | 1 | One-cycle reject pulse |
| group_o | output | 1 | 0 = physical, 1 = group acceptance |
| tx_off_o | output | 1 | Remote transmitter-off pulse |
| tx_on_o | output | 1 | Remote transmitter-on pulse |

## Verification
The bench targets the boundaries between the address classes:
- **Broadcast with broadcast disabled but multicast enabled.** A design that treated broadcast as an ordinary hashed multicast would accept this frame.
- **Single differing byte.** A destination that differs from the station address only in its last byte catches a comparison that skips bytes.
- **Hash bit selection.** Hash indices that land in different table bytes expose a swapped byte/bit split.
- **Runt edge.** Lengths of 63 and 64 catch an off-by-one runt limit.
- **Remote control with an errored frame.** A design that forgot the error gate would pulse the transmitter control on a damaged frame.
- **Remote control with the feature off, and mutual exclusion.** A design with crossed remote pulses would fail these checks.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

   // Result of the address stage, held from the destination until end-of-frame
   typedef struct packed {
      logic addr_ok;   // destination passes the address rules
      logic grp;       // destination is a group address
      logic rd_off;    // group frame hashing to the transmitter-off slot
      logic rd_on;     // group frame hashing to the transmitter-on slot
   } addr_verdict_t;

endpackage

// File: rtl/rxaf_addr_match.sv
module rxaf_addr_match
   import rxaf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_W     = 64,
   localparam int ADDR_W    = ADDR_BYTES * 8,
   localparam int IDX_W     = $clog2(HASH_W)
) (
   input  logic [ADDR_W-1:0] dst_i,
   input  logic [ADDR_W-1:0] stn_i,
   input  logic [HASH_W-1:0] hash_tbl_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              bcast_en_i,
   input  logic              mcast_en_i,
   input  logic              promisc_i,
   output addr_verdict_t     verdict_o
);

   localparam logic [IDX_W-1:0] OFF_SLOT = IDX_W'(HASH_W - 2);
   localparam logic [IDX_W-1:0] ON_SLOT  = IDX_W'(HASH_W - 1);

   logic [ADDR_BYTES-1:0] byte_eq;
   logic [ADDR_BYTES-1:0] byte_ones;
   logic                  hash_hit;

   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
      assign byte_eq[b]   = (dst_i[8*b +: 8] == stn_i[8*b +: 8]);
      assign byte_ones[b] = &dst_i[8*b +: 8];
   end

   // Table organised as bytes when wide enough, else as a flat bit vector
   if (HASH_W >= 8) begin : g_hash_bytes
      logic [7:0] hbyte;
      assign hbyte    = hash_tbl_i[{idx_i[IDX_W-1:3], 3'b000} +: 8];
      assign hash_hit = hbyte[idx_i[2:0]];
   end else begin : g_hash_flat
      assign hash_hit = hash_tbl_i[idx_i];
   end

   logic is_grp, is_bcast, phys_ok, grp_ok;

   always_comb begin
      is_grp   = dst_i[0];
      is_bcast = &byte_ones;
      phys_ok  = !is_grp && (promisc_i || (&byte_eq));
      grp_ok   = is_grp && (is_bcast ? bcast_en_i : (mcast_en_i && hash_hit));
      verdict_o.addr_ok = phys_ok || grp_ok;
      verdict_o.grp     = is_grp;
      verdict_o.rd_off  = is_grp && (idx_i == OFF_SLOT);
      verdict_o.rd_on   = is_grp && (idx_i == ON_SLOT);
   end

endmodule

// File: rtl/rxaf_frame_qual.sv
module rxaf_frame_qual #(
   parameter int LEN_W   = 11,
   parameter int MIN_LEN = 64
) (
   input  logic [LEN_W-1:0] len_i,
   input  logic             crc_err_i,
   input  logic             align_err_i,
   input  logic             runt_ok_i,
   input  logic             save_err_i,
   output logic             len_ok_o,
   output logic             err_ok_o,
   output logic             clean_o
);

   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

   always_comb begin
      clean_o  = !(crc_err_i || align_err_i);
      len_ok_o = (len_i >= MIN_L) || runt_ok_i;
      err_ok_o = clean_o || save_err_i;
   end

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
   import rxaf_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dst_valid_i,
   input  addr_verdict_t verdict_i,
   input  logic          eof_i,
   input  logic          len_ok_i,
   input  logic          err_ok_i,
   input  logic          clean_i,
   input  logic          atd_i,
   output logic          accept_o,
   output logic          reject_o,
   output logic          group_o,
   output logic          tx_off_o,
   output logic          tx_on_o
);

   addr_verdict_t held;
   logic          keep;

   always_comb keep = held.addr_ok && len_ok_i && err_ok_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held     <= '0;
         accept_o <= 1'b0;
         reject_o <= 1'b0;
         group_o  <= 1'b0;
         tx_off_o <= 1'b0;
         tx_on_o  <= 1'b0;
      end else begin
         if (dst_valid_i) held <= verdict_i;
         accept_o <= eof_i && keep;
         reject_o <= eof_i && !keep;
         if (eof_i) group_o <= held.grp;
         tx_off_o <= eof_i && atd_i && clean_i && held.rd_off;
         tx_on_o  <= eof_i && atd_i && clean_i && held.rd_on;
      end
   end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
   import rxaf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_W     = 64,
   parameter int LEN_W      = 11,
   parameter int MIN_LEN    = 64,
   localparam int ADDR_W    = ADDR_BYTES * 8,
   localparam int IDX_W     = $clog2(HASH_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dst_valid_i,
   input  logic [ADDR_W-1:0] dst_i,
   input  logic [IDX_W-1:0]  hash_idx_i,
   input  logic              eof_i,
   input  logic [LEN_W-1:0]  frame_len_i,
   input  logic              crc_err_i,
   input  logic              align_err_i,
   input  logic [ADDR_W-1:0] stn_addr_i,
   input  logic [HASH_W-1:0] hash_tbl_i,
   input  logic              cfg_bcast_i,
   input  logic              cfg_mcast_i,
   input  logic              cfg_promisc_i,
   input  logic              cfg_runt_i,
   input  logic              cfg_save_err_i,
   input  logic              cfg_atd_i,
   output logic              accept_o,
   output logic              reject_o,
   output logic              group_o,
   output logic              tx_off_o,
   output logic              tx_on_o
);

   if (ADDR_BYTES < 1) begin : g_bad_bytes
      $error("ADDR_BYTES must be at least 1");
   end
   if (HASH_W < 4 || (1 << IDX_W) != HASH_W) begin : g_bad_hash
      $error("HASH_W must be a power of two of at least 4");
   end
   if (MIN_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("MIN_LEN does not fit in LEN_W bits");
   end

   addr_verdict_t verdict;
   logic          len_ok, err_ok, clean;

   rxaf_addr_match #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_match (
      .dst_i      (dst_i),
      .stn_i      (stn_addr_i),
      .hash_tbl_i (hash_tbl_i),
      .idx_i      (hash_idx_i),
      .bcast_en_i (cfg_bcast_i),
      .mcast_en_i (cfg_mcast_i),
      .promisc_i  (cfg_promisc_i),
      .verdict_o  (verdict)
   );

   rxaf_frame_qual #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_qual (
      .len_i       (frame_len_i),
      .crc_err_i   (crc_err_i),
      .align_err_i (align_err_i),
      .runt_ok_i   (cfg_runt_i),
      .save_err_i  (cfg_save_err_i),
      .len_ok_o    (len_ok),
      .err_ok_o    (err_ok),
      .clean_o     (clean)
   );

   rxaf_decide u_decide (
      .clk         (clk),
      .rst_n       (rst_n),
      .dst_valid_i (dst_valid_i),
      .verdict_i   (verdict),
      .eof_i       (eof_i),
      .len_ok_i    (len_ok),
      .err_ok_i    (err_ok),
      .clean_i     (clean),
      .atd_i       (cfg_atd_i),
      .accept_o    (accept_o),
      .reject_o    (reject_o),
      .group_o     (group_o),
      .tx_off_o    (tx_off_o),
      .tx_on_o     (tx_on_o)
   );

endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk #(
   parameter int LEN_W   = 11,
   parameter int MIN_LEN = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             eof_i,
   input logic [LEN_W-1:0] frame_len_i,
   input logic             crc_err_i,
   input logic             align_err_i,
   input logic             cfg_runt_i,
   input logic             cfg_save_err_i,
   input logic             cfg_atd_i,
   input logic             accept_o,
   input logic             reject_o,
   input logic             tx_off_o,
   input logic             tx_on_o
);

   assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eof_i |=> (accept_o ^ reject_o));

   assert_no_stray_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o || reject_o) |-> $past(eof_i));

   assert_runt_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> ($past(frame_len_i) >= LEN_W'(MIN_LEN) || $past(cfg_runt_i)));

   assert_err_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> (!($past(crc_err_i) || $past(align_err_i)) || $past(cfg_save_err_i)));

   assert_remote_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_off_o && tx_on_o));

   assert_remote_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_off_o || tx_on_o) |-> ($past(eof_i) && $past(cfg_atd_i)
                                 && !$past(crc_err_i) && !$past(align_err_i)));

endmodule

bind rx_dest_filter rx_dest_filter_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .eof_i          (eof_i),
   .frame_len_i    (frame_len_i),
   .crc_err_i      (crc_err_i),
   .align_err_i    (align_err_i),
   .cfg_runt_i     (cfg_runt_i),
   .cfg_save_err_i (cfg_save_err_i),
   .cfg_atd_i      (cfg_atd_i),
   .accept_o       (accept_o),
   .reject_o       (reject_o),
   .tx_off_o       (tx_off_o),
   .tx_on_o        (tx_on_o)
);

// File: tb/rx_dest_filter_bench.sv
module rx_dest_filter_bench;

   localparam logic [47:0] STN   = 48'hA5_4C_3B_2A_19_02;
   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MCAST = 48'h00_00_5E_00_00_01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dst_valid = 1'b0;
   logic [47:0] dst = '0;
   logic [5:0]  hidx = '0;
   logic        eof = 1'b0;
   logic [10:0] flen = '0;
   logic        crc = 1'b0, aln = 1'b0;
   logic [63:0] tbl = (64'd1 << 5) | (64'd1 << 45);
   logic        c_bc = 0, c_mc = 0, c_pro = 0, c_runt = 0, c_save = 0, c_atd = 0;
   logic        acc, rej, grp, toff, ton;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   rx_dest_filter u_rx_dest_filter (
      .clk(clk), .rst_n(rst_n), .dst_valid_i(dst_valid), .dst_i(dst),
      .hash_idx_i(hidx), .eof_i(eof), .frame_len_i(flen), .crc_err_i(crc),
      .align_err_i(aln), .stn_addr_i(STN), .hash_tbl_i(tbl),
      .cfg_bcast_i(c_bc), .cfg_mcast_i(c_mc), .cfg_promisc_i(c_pro),
      .cfg_runt_i(c_runt), .cfg_save_err_i(c_save), .cfg_atd_i(c_atd),
      .accept_o(acc), .reject_o(rej), .group_o(grp), .tx_off_o(toff), .tx_on_o(ton)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%b exp=%b", req, act, exp);
      end
   endtask

   // Send one frame; on return the verdict cycle is being observed
   task automatic frame(input logic [47:0] d, input logic [5:0] ix,
                        input int len, input logic ce, input logic ae);
      @(negedge clk);
      dst_valid = 1'b1; dst = d; hidx = ix;
      @(negedge clk);
      dst_valid = 1'b0; eof = 1'b1; flen = 11'(len); crc = ce; aln = ae;
      @(negedge clk);
      eof = 1'b0; crc = 1'b0; aln = 1'b0;
   endtask

   task automatic expect_verdict(input string req, input logic a);
      chk(req, acc, a);
      chk(req, rej, !a);
   endtask

   task automatic t_reset();
      chk("R10 accept", acc, 1'b0);
      chk("R10 reject", rej, 1'b0);
      chk("R10 group", grp, 1'b0);
      chk("R10 txoff", toff, 1'b0);
      chk("R10 txon", ton, 1'b0);
   endtask

   task automatic t_unicast();
      frame(STN, 6'd0, 100, 0, 0);
      expect_verdict("R1 match", 1'b1);
      chk("R7 physical", grp, 1'b0);
      @(negedge clk);
      chk("R8 pulse ends acc", acc, 1'b0);
      chk("R8 pulse ends rej", rej, 1'b0);
      frame({8'h77, STN[39:0]}, 6'd0, 100, 0, 0);
      expect_verdict("R1 last byte differs", 1'b0);
   endtask

   task automatic t_bcast();
      c_mc = 1; tbl = '1;
      frame(BCAST, 6'd63, 100, 0, 0);
      expect_verdict("R2 bcast off", 1'b0);
      c_bc = 1;
      frame(BCAST, 6'd10, 100, 0, 0);
      expect_verdict("R2 bcast on", 1'b1);
      chk("R7 group bcast", grp, 1'b1);
      c_mc = 0; c_bc = 0; tbl = (64'd1 << 5) | (64'd1 << 45);
   endtask

   task automatic t_mcast();
      frame(MCAST, 6'd5, 100, 0, 0);
      expect_verdict("R3 mcast disabled", 1'b0);
      c_mc = 1;
      frame(MCAST, 6'd5, 100, 0, 0);
      expect_verdict("R3 hash byte0 bit5", 1'b1);
      chk("R7 group mcast", grp, 1'b1);
      frame(MCAST, 6'd45, 100, 0, 0);
      expect_verdict("R3 hash byte5 bit5", 1'b1);
      frame(MCAST, 6'd6, 100, 0, 0);
      expect_verdict("R3 hash miss", 1'b0);
      frame(MCAST, 6'd40, 100, 0, 0);
      expect_verdict("R3 hash miss byte5", 1'b0);
      chk("R7 group held", grp, 1'b1);
      c_mc = 0;
   endtask

   task automatic t_promisc();
      c_pro = 1;
      frame(48'h12_34_56_78_9A_BC, 6'd0, 100, 0, 0);
      expect_verdict("R4 promisc physical", 1'b1);
      chk("R7 promisc physical", grp, 1'b0);
      frame(MCAST, 6'd6, 100, 0, 0);
      expect_verdict("R4 promisc not group", 1'b0);
      c_pro = 0;
   endtask

   task automatic t_runt();
      frame(STN, 6'd0, 63, 0, 0);
      expect_verdict("R5 runt 63", 1'b0);
      frame(STN, 6'd0, 64, 0, 0);
      expect_verdict("R5 len 64", 1'b1);
      c_runt = 1;
      frame(STN, 6'd0, 20, 0, 0);
      expect_verdict("R5 runt kept", 1'b1);
      c_runt = 0;
   endtask

   task automatic t_errors();
      frame(STN, 6'd0, 100, 1, 0);
      expect_verdict("R6 crc drop", 1'b0);
      frame(STN, 6'd0, 100, 0, 1);
      expect_verdict("R6 align drop", 1'b0);
      c_save = 1;
      frame(STN, 6'd0, 100, 1, 1);
      expect_verdict("R6 errors kept", 1'b1);
      c_save = 0;
   endtask

   task automatic t_remote();
      frame(MCAST, 6'd62, 100, 0, 0);
      chk("R9 atd off no txoff", toff, 1'b0);
      chk("R9 atd off no txon", ton, 1'b0);
      c_atd = 1;
      frame(MCAST, 6'd62, 100, 0, 0);
      chk("R9 slot62 txoff", toff, 1'b1);
      chk("R9 slot62 no txon", ton, 1'b0);
      expect_verdict("R9 slot62 rejected by filter", 1'b0);
      @(negedge clk);
      chk("R9 txoff one cycle", toff, 1'b0);
      frame(MCAST, 6'd63, 100, 0, 0);
      chk("R9 slot63 txon", ton, 1'b1);
      chk("R9 slot63 no txoff", toff, 1'b0);
      frame(MCAST, 6'd62, 100, 1, 0);
      chk("R9 errored no txoff", toff, 1'b0);
      frame(STN, 6'd62, 100, 0, 0);
      chk("R9 physical no txoff", toff, 1'b0);
      c_atd = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unicast();
      t_bcast();
      t_mcast();
      t_promisc();
      t_runt();
      t_errors();
      t_remote();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule